// File: doc/BRIEF.md
# Vector Memory Element Sequencer

The sequencer takes one vector memory command and breaks it into single-element memory requests. Each command carries a base address, a stride, a set of per-element offsets, a vector length, a predicate mask and an addressing mode. Three address forms are supported: contiguous elements of a fixed size, elements spaced by a programmable stride, and elements placed at a per-element offset from the base. Elements whose predicate bit is clear are stepped over and cause no request. Requests go out in strictly ascending element order, with at most one in flight at a time.

A speculative fail-first option changes how faults are handled. Element 0 is always treated as a normal access, so a fault on element 0 is reported as an exception. A fault on any later element produces no exception. Instead the vector length is cut back so that it covers only the elements before the fault. Under fail-first the indexed form is not allowed, and its mode code selects the strided form instead. Two configuration inputs allow earlier truncation under fail-first: a minimal mode that always stops after element 0, and a line mode that stops before any element whose address starts a new aligned line. Fail-first requested together with vertical (one element per instruction) execution is rejected as illegal.

Both the command interface and the request port use valid/ready handshakes. A command is taken only on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from acceptance until the completion pulse has ended, which holds off the next command. Once `req_valid` is raised, it and the request fields stay constant until `req_ready` is seen high. Responses have no back-pressure: exactly one `resp_valid` cycle is expected for each accepted request, and it may come at any later cycle. Completion is a single-cycle `done` pulse, and the result fields are valid only during that cycle.

Top module: `vec_elem_seq`

## Requirements
- R1: `cmd_ready` is high only while the block is idle. It is high after reset, and it stays low from the acceptance of a command until the cycle after its `done` pulse.
- R2: Mode code 00 (contiguous) issues element i at address base + i*ELEM_BYTES, with the sum taken modulo 2^ADDR_W.
- R3: Mode code 01 issues element i at base + i*stride. Under fail-first, codes 10 and 11 also select this strided form.
- R4: Mode codes 10 and 11 without fail-first (indexed) issue element i at base + offset[i], where offset[i] is bits [i*ADDR_W +: ADDR_W] of `cmd_offsets`.
- R5: Only elements with index below VL whose bit in `cmd_pred` is 1 (bit i for element i) are requested. `req_elem` carries the element index.
- R6: Requests are issued in strictly ascending element order. No new request is raised while one is still waiting for its response, and a raised request holds its address and index until it is accepted.
- R7: Without fail-first, a faulting response ends the command with `done_exc`=1, `done_fault_idx` set to that element, and `done_vl` equal to the command's VL.
- R8: Under fail-first, a fault on element 0 ends the command with `done_exc`=1, `done_fault_idx`=0 and `done_vl` unchanged.
- R9: Under fail-first, a fault on element i≥1 ends the command with `done_exc`=0, `done_vl`=i and `done_fault_idx`=i.
- R10: Under fail-first with `cfg_min_ff`=1, no element above 0 is requested. If VL≥2 the command ends with `done_vl`=1 and `done_exc`=0.
- R11: Under fail-first with `cfg_line_trunc`=1, an active element i≥1 whose address is a multiple of LINE_BYTES is not requested. The command then ends with `done_vl`=i.
- R12: A command with both fail-first and vertical set issues no request. It ends with `done_illegal`=1, `done_vl`=0 and `done_exc`=0. No other command sets `done_illegal`.
- R13: `done` is a single-cycle pulse. A command with no fault and no truncation reports `done_vl` equal to its VL (values above MAXVL are taken as MAXVL), with `done_exc`=0 and `done_fault_idx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_mode | input | 2 | 00 contiguous, 01 strided, 1x indexed (strided under fail-first) |
| cmd_ffirst | input | 1 | Speculative fail-first enable |
| cmd_vertical | input | 1 | Vertical execution flag (illegal with fail-first) |
| cmd_base | input | ADDR_W | Base address |
| cmd_stride | input | ADDR_W | Stride in bytes for the strided form |
| cmd_offsets | input | MAXVL*ADDR_W | Per-element offsets for the indexed form |
| cmd_vl | input | VL_W | Vector length |
| cmd_pred | input | MAXVL | Predicate mask, bit i for element i |
| cfg_min_ff | input | 1 | Fail-first stops after element 0 |
| cfg_line_trunc | input | 1 | Fail-first stops at a line boundary |
| req_valid | output | 1 | Element request offered |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Element address |
| req_elem | output | IDX_W | Element index |
| resp_valid | input | 1 | Response for the outstanding request |
| resp_fault | input | 1 | The responded element faulted |
| done | output | 1 | One-cycle completion pulse |
| done_vl | output | VL_W | Final, possibly truncated, VL |
| done_exc | output | 1 | Exception to be raised |
| done_fault_idx | output | IDX_W | Element that faulted (0 when none) |
| done_illegal | output | 1 | Fail-first with vertical rejected |

## Verification
The assertions check handshake and ordering rules that must hold on every cycle. These are: ready low while busy; a single outstanding request; requests held under back-pressure; element indices rising and below VL; `done` as a single-cycle pulse; a final VL never above the command's VL; no late exception under fail-first; and an illegal result only for the rejected combination. Only the bench's scenarios can show that the right addresses are generated for each mode, and that the right elements are skipped. The same holds for the exact truncated VL chosen by a late fault or by the minimal and line policies, and for the error fields reported by each fault position. The bench works these out from the requirements for every combination of mode, predicate, fault position, length and policy.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SCAN,
    S_REQ,
    S_WAIT,
    S_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    AM_UNIT,
    AM_STRIDE,
    AM_INDEX
  } addr_mode_t;
endpackage

// File: rtl/vseq_addr_gen.sv
module vseq_addr_gen
  import vseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MAXVL      = 8,
  parameter int ELEM_BYTES = 4,
  localparam int IDX_W     = $clog2(MAXVL)
) (
  input  addr_mode_t              amode,
  input  logic [ADDR_W-1:0]       base,
  input  logic [ADDR_W-1:0]       stride,
  input  logic [MAXVL*ADDR_W-1:0] offsets,
  input  logic [IDX_W-1:0]        idx,
  output logic [ADDR_W-1:0]       addr
);
  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] sel_off;

  assign idx_ext = ADDR_W'(idx);
  assign sel_off = offsets[idx*ADDR_W +: ADDR_W];

  always_comb begin
    unique case (amode)
      AM_STRIDE: addr = base + idx_ext * stride;
      AM_INDEX:  addr = base + sel_off;
      default:   addr = base + idx_ext * ADDR_W'(ELEM_BYTES);
    endcase
  end
endmodule

// File: rtl/vseq_stop_check.sv
module vseq_stop_check #(
  parameter int ADDR_W     = 16,
  parameter int MAXVL      = 8,
  parameter int LINE_BYTES = 32,
  localparam int VL_W      = $clog2(MAXVL + 1),
  localparam int LINE_LOG2 = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 0
) (
  input  logic              ffirst,
  input  logic              min_en,
  input  logic              line_en,
  input  logic [VL_W-1:0]   cur,
  input  logic [VL_W-1:0]   vl,
  input  logic [ADDR_W-1:0] addr,
  output logic              at_end,
  output logic              min_stop,
  output logic              line_stop
);
  logic past_first;
  logic aligned;

  assign past_first = (cur != '0);
  assign at_end     = (cur >= vl);
  assign min_stop   = ffirst && min_en && past_first;

  generate
    if (LINE_LOG2 > 0) begin : g_line
      assign aligned = (addr[LINE_LOG2-1:0] == '0);
    end else begin : g_noline
      assign aligned = 1'b1;
    end
  endgenerate

  assign line_stop = ffirst && line_en && past_first && aligned;
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MAXVL      = 8,
  parameter int ELEM_BYTES = 4,
  parameter int LINE_BYTES = 32,
  localparam int VL_W      = $clog2(MAXVL + 1),
  localparam int IDX_W     = $clog2(MAXVL)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [1:0]              cmd_mode,
  input  logic                    cmd_ffirst,
  input  logic                    cmd_vertical,
  input  logic [ADDR_W-1:0]       cmd_base,
  input  logic [ADDR_W-1:0]       cmd_stride,
  input  logic [MAXVL*ADDR_W-1:0] cmd_offsets,
  input  logic [VL_W-1:0]         cmd_vl,
  input  logic [MAXVL-1:0]        cmd_pred,
  input  logic                    cfg_min_ff,
  input  logic                    cfg_line_trunc,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [ADDR_W-1:0]       req_addr,
  output logic [IDX_W-1:0]        req_elem,
  input  logic                    resp_valid,
  input  logic                    resp_fault,
  output logic                    done,
  output logic [VL_W-1:0]         done_vl,
  output logic                    done_exc,
  output logic [IDX_W-1:0]        done_fault_idx,
  output logic                    done_illegal
);
  localparam logic [VL_W-1:0] VL_MAX = VL_W'(MAXVL);

  seq_state_t              state;
  addr_mode_t              amode_r, amode_in;
  logic [ADDR_W-1:0]       base_r, stride_r, addr_r, gen_addr;
  logic [MAXVL*ADDR_W-1:0] off_r;
  logic [MAXVL-1:0]        pred_r;
  logic [VL_W-1:0]         vl_r, cur, res_vl;
  logic                    ff_r, min_r, line_r;
  logic                    res_exc, res_ill;
  logic [IDX_W-1:0]        res_fidx;
  logic                    at_end, min_stop, line_stop;
  logic                    accept;

  assign accept = cmd_valid && cmd_ready;

  always_comb begin
    if (cmd_mode[1]) amode_in = cmd_ffirst ? AM_STRIDE : AM_INDEX;
    else if (cmd_mode[0]) amode_in = AM_STRIDE;
    else amode_in = AM_UNIT;
  end

  vseq_addr_gen #(
    .ADDR_W(ADDR_W), .MAXVL(MAXVL), .ELEM_BYTES(ELEM_BYTES)
  ) u_addr (
    .amode(amode_r), .base(base_r), .stride(stride_r), .offsets(off_r),
    .idx(cur[IDX_W-1:0]), .addr(gen_addr)
  );

  vseq_stop_check #(
    .ADDR_W(ADDR_W), .MAXVL(MAXVL), .LINE_BYTES(LINE_BYTES)
  ) u_stop (
    .ffirst(ff_r), .min_en(min_r), .line_en(line_r), .cur(cur), .vl(vl_r),
    .addr(gen_addr), .at_end(at_end), .min_stop(min_stop), .line_stop(line_stop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      amode_r  <= AM_UNIT;
      base_r   <= '0;
      stride_r <= '0;
      off_r    <= '0;
      pred_r   <= '0;
      vl_r     <= '0;
      cur      <= '0;
      addr_r   <= '0;
      ff_r     <= 1'b0;
      min_r    <= 1'b0;
      line_r   <= 1'b0;
      res_vl   <= '0;
      res_exc  <= 1'b0;
      res_ill  <= 1'b0;
      res_fidx <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          amode_r  <= amode_in;
          base_r   <= cmd_base;
          stride_r <= cmd_stride;
          off_r    <= cmd_offsets;
          pred_r   <= cmd_pred;
          vl_r     <= (cmd_vl > VL_MAX) ? VL_MAX : cmd_vl;
          ff_r     <= cmd_ffirst;
          min_r    <= cfg_min_ff;
          line_r   <= cfg_line_trunc;
          cur      <= '0;
          res_exc  <= 1'b0;
          res_fidx <= '0;
          res_vl   <= '0;
          if (cmd_ffirst && cmd_vertical) begin
            res_ill <= 1'b1;
            state   <= S_DONE;
          end else begin
            res_ill <= 1'b0;
            state   <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (at_end) begin
            res_vl <= vl_r;
            state  <= S_DONE;
          end else if (min_stop) begin
            res_vl <= VL_W'(1);
            state  <= S_DONE;
          end else if (!pred_r[cur[IDX_W-1:0]]) begin
            cur <= cur + 1'b1;
          end else if (line_stop) begin
            res_vl <= cur;
            state  <= S_DONE;
          end else begin
            addr_r <= gen_addr;
            state  <= S_REQ;
          end
        end
        S_REQ: if (req_ready) state <= S_WAIT;
        S_WAIT: if (resp_valid) begin
          if (resp_fault) begin
            res_fidx <= cur[IDX_W-1:0];
            if (!ff_r || cur == '0) begin
              res_exc <= 1'b1;
              res_vl  <= vl_r;
            end else begin
              res_vl  <= cur;
            end
            state <= S_DONE;
          end else begin
            cur   <= cur + 1'b1;
            state <= S_SCAN;
          end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready      = (state == S_IDLE);
  assign req_valid      = (state == S_REQ);
  assign req_addr       = addr_r;
  assign req_elem       = cur[IDX_W-1:0];
  assign done           = (state == S_DONE);
  assign done_vl        = res_vl;
  assign done_exc       = res_exc;
  assign done_fault_idx = res_fidx;
  assign done_illegal   = res_ill;
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
  parameter int ADDR_W     = 16,
  parameter int MAXVL      = 8,
  localparam int VL_W      = $clog2(MAXVL + 1),
  localparam int IDX_W     = $clog2(MAXVL)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_ffirst,
  input logic              cmd_vertical,
  input logic [VL_W-1:0]   cmd_vl,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [IDX_W-1:0]  req_elem,
  input logic              resp_valid,
  input logic              done,
  input logic [VL_W-1:0]   done_vl,
  input logic              done_exc,
  input logic [IDX_W-1:0]  done_fault_idx,
  input logic              done_illegal
);
  logic            busy, outstanding, ff_c, vert_c, issued;
  logic [VL_W-1:0] vl_c;
  logic [IDX_W-1:0] last_el;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; outstanding <= 1'b0; ff_c <= 1'b0; vert_c <= 1'b0;
      issued <= 1'b0; vl_c <= '0; last_el <= '0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        busy   <= 1'b1;
        ff_c   <= cmd_ffirst;
        vert_c <= cmd_vertical;
        issued <= 1'b0;
        vl_c   <= (cmd_vl > VL_W'(MAXVL)) ? VL_W'(MAXVL) : cmd_vl;
      end else if (done) begin
        busy <= 1'b0;
      end
      if (req_valid && req_ready) begin
        outstanding <= 1'b1;
        issued      <= 1'b1;
        last_el     <= req_elem;
      end else if (resp_valid) begin
        outstanding <= 1'b0;
      end
    end
  end

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !req_valid);
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_elem)));
  assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && issued && busy) |-> (req_elem > last_el));
  assert_elem_in_vl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (VL_W'(req_elem) < vl_c));
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_vl_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy) |-> (done_vl <= vl_c));
  assert_no_late_exc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy && done_exc && ff_c) |-> (done_fault_idx == '0));
  assert_illegal_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy && done_illegal) |-> (ff_c && vert_c && !issued));
endmodule

bind vec_elem_seq vseq_checker #(.ADDR_W(ADDR_W), .MAXVL(MAXVL)) u_chk (.*);

// File: tb/vec_elem_seq_tb.sv
`timescale 1ns/1ps
module vec_elem_seq_tb;
  localparam int ADDR_W = 16;
  localparam int MAXVL  = 8;
  localparam int EB     = 4;
  localparam int LB     = 32;
  localparam int VL_W   = $clog2(MAXVL + 1);
  localparam int IDX_W  = $clog2(MAXVL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                    cmd_valid = 0, cmd_ffirst = 0, cmd_vertical = 0;
  logic [1:0]              cmd_mode = 0;
  logic [ADDR_W-1:0]       cmd_base = 0, cmd_stride = 0;
  logic [MAXVL*ADDR_W-1:0] cmd_offsets = 0;
  logic [VL_W-1:0]         cmd_vl = 0;
  logic [MAXVL-1:0]        cmd_pred = 0;
  logic                    cfg_min_ff = 0, cfg_line_trunc = 0;
  logic                    req_ready = 0, resp_valid = 0, resp_fault = 0;
  logic                    cmd_ready, req_valid, done, done_exc, done_illegal;
  logic [ADDR_W-1:0]       req_addr;
  logic [IDX_W-1:0]        req_elem, done_fault_idx;
  logic [VL_W-1:0]         done_vl;

  int checks = 0;
  int fails  = 0;

  vec_elem_seq #(.ADDR_W(ADDR_W), .MAXVL(MAXVL), .ELEM_BYTES(EB), .LINE_BYTES(LB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_ffirst(cmd_ffirst), .cmd_vertical(cmd_vertical),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_offsets(cmd_offsets),
    .cmd_vl(cmd_vl), .cmd_pred(cmd_pred), .cfg_min_ff(cfg_min_ff),
    .cfg_line_trunc(cfg_line_trunc), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_elem(req_elem), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .done(done), .done_vl(done_vl), .done_exc(done_exc),
    .done_fault_idx(done_fault_idx), .done_illegal(done_illegal)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] off_of(input int i);
    return ADDR_W'(16'h0100 + i * 20);
  endfunction

  // expected results, from the requirements
  int e_vl, e_exc, e_fidx, e_ill, n_exp;
  int e_el[MAXVL];
  int e_ad[MAXVL];
  string e_tag, a_tag;

  task automatic model(input int mode, input bit ff, input bit vert, input bit mn,
                       input bit ln, input int base, input int stride, input int vl,
                       input logic [MAXVL-1:0] pred, input int fault_el);
    int v;
    v = (vl > MAXVL) ? MAXVL : vl;
    n_exp = 0; e_exc = 0; e_fidx = 0; e_ill = 0; e_vl = v; e_tag = "R13";
    if (mode == 0) a_tag = "R2";
    else if (mode == 1 || ff) a_tag = "R3";
    else a_tag = "R4";
    if (ff && vert) begin
      e_ill = 1; e_vl = 0; e_tag = "R12";
      return;
    end
    for (int i = 0; i < v; i++) begin
      int a;
      if (ff && i >= 1 && mn) begin e_vl = 1; e_tag = "R10"; break; end
      if (!pred[i]) continue;
      if (mode == 0) a = base + i * EB;
      else if (mode == 1 || ff) a = base + i * stride;
      else a = base + int'(off_of(i));
      a = a % 65536;
      if (ff && i >= 1 && ln && (a % LB) == 0) begin e_vl = i; e_tag = "R11"; break; end
      e_el[n_exp] = i; e_ad[n_exp] = a; n_exp++;
      if (i == fault_el) begin
        e_fidx = i;
        if (!ff) begin e_exc = 1; e_tag = "R7"; end
        else if (i == 0) begin e_exc = 1; e_tag = "R8"; end
        else begin e_vl = i; e_tag = "R9"; end
        break;
      end
    end
  endtask

  task automatic run(input int mode, input bit ff, input bit vert, input bit mn,
                     input bit ln, input int base, input int stride, input int vl,
                     input logic [MAXVL-1:0] pred, input int fault_el);
    int seen = 0, guard = 0, last = -1, pend_el = 0;
    bit pend = 0, tog = 0, fin = 0;
    model(mode, ff, vert, mn, ln, base, stride, vl, pred, fault_el);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_mode = 2'(mode); cmd_ffirst = ff; cmd_vertical = vert;
    cfg_min_ff = mn; cfg_line_trunc = ln; cmd_base = ADDR_W'(base);
    cmd_stride = ADDR_W'(stride); cmd_vl = VL_W'(vl); cmd_pred = pred;
    for (int i = 0; i < MAXVL; i++) cmd_offsets[i*ADDR_W +: ADDR_W] = off_of(i);
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ready == 1'b0, "R1 busy ready", int'(cmd_ready), 0);
    while (!fin) begin
      req_ready = 0; resp_valid = 0; resp_fault = 0;
      if (done) begin
        chk(int'(done_vl) == e_vl, {e_tag, " vl"}, int'(done_vl), e_vl);
        chk(int'(done_exc) == e_exc, {e_tag, " exc"}, int'(done_exc), e_exc);
        chk(int'(done_fault_idx) == e_fidx, {e_tag, " fidx"}, int'(done_fault_idx), e_fidx);
        chk(int'(done_illegal) == e_ill, "R12 illegal", int'(done_illegal), e_ill);
        chk(seen == n_exp, "R5 request count", seen, n_exp);
        fin = 1;
      end else begin
        if (pend) begin
          chk(!req_valid, "R6 single outstanding", int'(req_valid), 0);
          resp_valid = 1;
          resp_fault = (pend_el == fault_el);
          pend = 0;
        end else if (req_valid) begin
          tog = !tog;
          if (tog) begin
            req_ready = 1;
            chk(int'(req_elem) > last, "R6 ascending", int'(req_elem), last + 1);
            if (seen < n_exp) begin
              chk(int'(req_elem) == e_el[seen], "R5 element", int'(req_elem), e_el[seen]);
              chk(int'(req_addr) == e_ad[seen], a_tag, int'(req_addr), e_ad[seen]);
            end else begin
              chk(0, "R5 extra request", int'(req_elem), -1);
            end
            last = int'(req_elem); pend_el = int'(req_elem); pend = 1; seen++;
          end
        end
        guard++;
        if (guard > 400) begin
          chk(0, "R13 command timeout", guard, 400);
          fin = 1;
        end
        @(negedge clk);
      end
    end
    req_ready = 0; resp_valid = 0; resp_fault = 0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [MAXVL-1:0] preds [3];
    int faults [5];
    int vls [3];
    preds = '{8'hFF, 8'b1010_0110, 8'b0101_1011};
    faults = '{15, 0, 1, 3, 5};
    vls = '{0, 3, 12};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 reset ready", int'(cmd_ready), 1);
    chk(req_valid == 1'b0, "R6 reset req", int'(req_valid), 0);
    chk(done == 1'b0, "R13 reset done", int'(done), 0);
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 2; f++)
        for (int mn = 0; mn < 2; mn++)
          for (int ln = 0; ln < 2; ln++)
            for (int b = 0; b < 2; b++)
              for (int p = 0; p < 3; p++)
                for (int v = 0; v < 3; v++)
                  for (int fe = 0; fe < 5; fe++)
                    run(m, f[0], 1'b0, mn[0], ln[0], (b == 0) ? 16'h18 : 16'h04,
                        (b == 0) ? 8 : 12, vls[v], preds[p], faults[fe]);
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 2; f++)
        for (int p = 0; p < 3; p++)
          run(m, f[0], 1'b1, 1'b0, 1'b0, 16'h18, 8, 8, preds[p], 3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule